// File: doc/BRIEF.md
# Clock Reconfiguration Port Sequencer

This block reprograms a clock-management primitive over its dynamic reconfiguration port (a generic enable / write-enable / address / data-in / data-out / ready interface). Give it a feedback multiplier M, an input divider D and an output divider Dout, pulse start, and it walks a fixed list of ten configuration registers. For each register it reads the current contents, keeps the bits outside a 16-bit field mask, merges in the new field bits and writes the result back.

The field values come from the three divider settings. Each divider is encoded as a high count, a low count, an odd-edge flag and a bypass flag. A loop-filter word and a lock-detector word are taken from small internal tables indexed by M-1. The sequencer has only one port access in flight at a time. Every access must see ready within a programmable number of cycles, or the sequence aborts with an error.

Top module: `clk_reconf_seq`

## Requirements
- R1: The ten registers are visited in this order, by address: 0x08, 0x09, 0x16, 0x14, 0x15, 0x18, 0x19, 0x1A, 0x4E, 0x4F.
- R2: Each register is read first and then written at the same address with (old & ~mask) | (value & mask). The masks are: 0x08 and 0x14 use 0xEFFF, 0x09 and 0x15 use 0x03FF, 0x16 uses 0x3FFF, 0x18 uses 0x03FF, 0x19 and 0x1A use 0x7FFF, 0x4E and 0x4F use 0x9900.
- R3: For a divider n, hi = n/2, lo = n - hi, edge = n mod 2 and bypass = (n == 1). Dout sets 0x08 to (hi<<6)|lo and 0x09 to (edge<<7)|(bypass<<6). M sets 0x14 and 0x15 in the same way. D sets 0x16 to (edge<<13)|(bypass<<12)|(hi<<6)|lo.
- R4: Let the lock word be L. Register 0x18 gets L[9:0]. Register 0x19 gets (L[20:16]<<10)|0x001. Register 0x1A gets (L[28:24]<<10)|0x3E9.
- R5: Let the filter word be F. Register 0x4E gets F[31:16] and register 0x4F gets F[15:0]. F comes from fixed ranges of M-1. Indices 0 to 4 each have their own word. Indices 5-8, 9-11 and 13-22 give 0x0100_xxxx words. Index 12 gives 0x08009090. Indices 23-36 give 0x01008090, indices 37-46 give 0x08001090, and any higher index gives 0x08008090.
- R6: The lock table has 36 entries, indexed by M-1. Any index of 36 or more yields 0x1F1F00FA.
- R7: A start with M, D or Dout equal to zero raises error_o for exactly one cycle, in the cycle after start, and makes no port access.
- R8: Ready must arrive within timeout_i+1 cycles after the enable cycle. If it does not, error_o pulses for one cycle and no further access is issued.
- R9: done_o is high for exactly one cycle, in the cycle after the ready of the final write. done_o and error_o are never high together.
- R10: start_i is ignored while a sequence is running. The latched settings stay unchanged and exactly 20 accesses are made.
- R11: The enable is high for one cycle per access. No new access is issued before the previous one has seen ready.
- R12: After reset, done_o, error_o and the port enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a reconfiguration sequence |
| mult_i | input | 7 | Feedback multiplier M |
| div_i | input | 7 | Input divider D |
| odiv_i | input | 8 | Output divider Dout |
| timeout_i | input | 16 | Ready wait limit in cycles |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle pulse on rejected start or ready timeout |
| drp_en_o | output | 1 | Port access enable |
| drp_we_o | output | 1 | Port write enable |
| drp_addr_o | output | 7 | Port register address |
| drp_di_o | output | 16 | Port write data |
| drp_do_i | input | 16 | Port read data |
| drp_rdy_i | input | 1 | Port access complete |

## Verification
Some properties are checked by assertions on every cycle. These are the single-cycle enable, that every write targets the address just read, the first address after an accepted start, the zero-setting rejection, the width of the done pulse and its exclusion with error, the stability of the latched settings while busy, and the clearing of the wait counter. The bench scenarios cover what no single-cycle property can show. Against a register model with a known initial pattern, a sweep over M from 1 to 72, with mixed D, Dout and ready latencies, checks the complete access order and the final merged contents of all ten registers. The lock and filter table boundaries are covered by that sweep. Separate scenarios check the timeout at its exact threshold and the abort that follows it.

// File: rtl/clk_reconf_pkg.sv
package clk_reconf_pkg;

  localparam int NSTEP = 10;
  localparam int SIW   = $clog2(NSTEP);
  localparam int AW    = 7;
  localparam int XW    = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_RD, S_RDW, S_WR, S_WRW
  } seq_state_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [XW-1:0] mask;
    logic [XW-1:0] val;
  } step_t;

  function automatic logic [15:0] div_hl(input logic [7:0] n);
    logic [7:0] hi, lo;
    hi = n >> 1;
    lo = n - hi;
    return ({8'd0, hi} << 6) | {8'd0, lo};
  endfunction

  function automatic logic [15:0] div_ex(input logic [7:0] n);
    return {8'd0, n[0], (n == 8'd1), 6'd0};
  endfunction

  function automatic logic [15:0] div_in(input logic [7:0] n);
    return {2'b00, n[0], (n == 8'd1), 12'd0} | div_hl(n);
  endfunction

  function automatic logic [31:0] filter_word(input logic [7:0] idx);
    if      (idx == 8'd0) return 32'h0100_1990;
    else if (idx == 8'd1) return 32'h0100_1190;
    else if (idx == 8'd2) return 32'h0100_9890;
    else if (idx == 8'd3) return 32'h0100_1890;
    else if (idx == 8'd4) return 32'h0100_8890;
    else if (idx <= 8'd8)  return 32'h0100_9090;
    else if (idx <= 8'd11) return 32'h0100_0890;
    else if (idx == 8'd12) return 32'h0800_9090;
    else if (idx <= 8'd22) return 32'h0100_1090;
    else if (idx <= 8'd36) return 32'h0100_8090;
    else if (idx <= 8'd46) return 32'h0800_1090;
    else                   return 32'h0800_8090;
  endfunction

  function automatic logic [31:0] lock_word(input logic [7:0] idx);
    logic [4:0] f;
    logic [9:0] c;
    f = 5'h1f;
    c = 10'h3e8;
    case (idx)
      8'd0, 8'd1: f = 5'h06;
      8'd2: f = 5'h08;
      8'd3: f = 5'h0b;
      8'd4: f = 5'h0e;
      8'd5: f = 5'h11;
      8'd6: f = 5'h13;
      8'd7: f = 5'h16;
      8'd8: f = 5'h19;
      8'd9: f = 5'h1c;
      8'd10: c = 10'h384;
      8'd11: c = 10'h339;
      8'd12: c = 10'h2ee;
      8'd13: c = 10'h2bc;
      8'd14: c = 10'h28a;
      8'd15: c = 10'h271;
      8'd16: c = 10'h23f;
      8'd17: c = 10'h226;
      8'd18: c = 10'h20d;
      8'd19: c = 10'h1f4;
      8'd20: c = 10'h1db;
      8'd21: c = 10'h1c2;
      8'd22: c = 10'h1a9;
      8'd23, 8'd24: c = 10'h190;
      8'd25: c = 10'h177;
      8'd26, 8'd27: c = 10'h15e;
      8'd28, 8'd29: c = 10'h145;
      8'd30, 8'd31, 8'd32: c = 10'h12c;
      8'd33, 8'd34, 8'd35: c = 10'h113;
      default: c = 10'h0fa;
    endcase
    return {3'b0, f, 3'b0, f, 6'b0, c};
  endfunction

  function automatic step_t build_step(input int g, input logic [7:0] m,
                                       input logic [7:0] d, input logic [7:0] o);
    logic [31:0] lck, flt;
    step_t s;
    lck = lock_word(m - 8'd1);
    flt = filter_word(m - 8'd1);
    s = '0;
    case (g)
      0: s = '{7'h08, 16'hefff, div_hl(o)};
      1: s = '{7'h09, 16'h03ff, div_ex(o)};
      2: s = '{7'h16, 16'h3fff, div_in(d)};
      3: s = '{7'h14, 16'hefff, div_hl(m)};
      4: s = '{7'h15, 16'h03ff, div_ex(m)};
      5: s = '{7'h18, 16'h03ff, {6'd0, lck[9:0]}};
      6: s = '{7'h19, 16'h7fff, {1'b0, lck[20:16], 10'h001}};
      7: s = '{7'h1a, 16'h7fff, {1'b0, lck[28:24], 10'h3e9}};
      8: s = '{7'h4e, 16'h9900, flt[31:16]};
      9: s = '{7'h4f, 16'h9900, flt[15:0]};
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/drp_wait_timer.sv
module drp_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          rdy_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (clear_i)                             cnt_q <= '0;
    else if (run_i && !rdy_i && cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && !rdy_i && (cnt_q >= limit_i);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/clk_reconf_steps.sv
module clk_reconf_steps
  import clk_reconf_pkg::*;
(
  input  logic [7:0]     m_i,
  input  logic [7:0]     d_i,
  input  logic [7:0]     o_i,
  input  logic [SIW-1:0] idx_i,
  output logic [AW-1:0]  addr_o,
  output logic [XW-1:0]  mask_o,
  output logic [XW-1:0]  val_o,
  output logic           rd_o
);
  localparam int NTAB = 2 ** SIW;
  step_t tab [NTAB];

  for (genvar g = 0; g < NTAB; g++) begin : g_step
    if (g < NSTEP) begin : g_used
      assign tab[g] = build_step(g, m_i, d_i, o_i);
    end else begin : g_pad
      assign tab[g] = '0;
    end
  end

  assign addr_o = tab[idx_i].addr;
  assign mask_o = tab[idx_i].mask;
  assign val_o  = tab[idx_i].val;
  assign rd_o   = (tab[idx_i].mask != '1);
endmodule

// File: rtl/clk_reconf_seq.sv
module clk_reconf_seq
  import clk_reconf_pkg::*;
#(
  parameter int MW = 7,
  parameter int DW = 7,
  parameter int OW = 8,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] mult_i,
  input  logic [DW-1:0] div_i,
  input  logic [OW-1:0] odiv_i,
  input  logic [TW-1:0] timeout_i,
  output logic          done_o,
  output logic          error_o,
  output logic          drp_en_o,
  output logic          drp_we_o,
  output logic [AW-1:0] drp_addr_o,
  output logic [XW-1:0] drp_di_o,
  input  logic [XW-1:0] drp_do_i,
  input  logic          drp_rdy_i
);
  seq_state_e     state_q;
  logic [SIW-1:0] step_q;
  logic [7:0]     m_q, d_q, o_q;
  logic [XW-1:0]  rd_q;
  logic [AW-1:0]  cur_addr, last_rd_addr_q;
  logic [XW-1:0]  cur_mask, cur_val;
  logic           cur_rd, expired, bad_cfg, last_step;

  assign bad_cfg   = (mult_i == '0) || (div_i == '0) || (odiv_i == '0);
  assign last_step = (step_q == SIW'(NSTEP - 1));

  clk_reconf_steps u_steps (
    .m_i(m_q), .d_i(d_q), .o_i(o_q), .idx_i(step_q),
    .addr_o(cur_addr), .mask_o(cur_mask), .val_o(cur_val), .rd_o(cur_rd)
  );

  drp_wait_timer #(.TW(TW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clear_i(state_q == S_RD || state_q == S_WR),
    .run_i(state_q == S_RDW || state_q == S_WRW),
    .rdy_i(drp_rdy_i), .limit_i(timeout_i), .expired_o(expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      m_q     <= '0;
      d_q     <= '0;
      o_q     <= '0;
      rd_q    <= '0;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      error_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          if (bad_cfg) error_o <= 1'b1;
          else begin
            m_q     <= 8'(mult_i);
            d_q     <= 8'(div_i);
            o_q     <= 8'(odiv_i);
            step_q  <= '0;
            state_q <= S_LOAD;
          end
        end
        S_LOAD: begin
          rd_q    <= '0;
          state_q <= cur_rd ? S_RD : S_WR;
        end
        S_RD:  state_q <= S_RDW;
        S_RDW: if (drp_rdy_i) begin
          rd_q    <= drp_do_i;
          state_q <= S_WR;
        end else if (expired) begin
          error_o <= 1'b1;
          state_q <= S_IDLE;
        end
        S_WR:  state_q <= S_WRW;
        S_WRW: if (drp_rdy_i) begin
          if (last_step) begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= S_LOAD;
          end
        end else if (expired) begin
          error_o <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign drp_en_o   = (state_q == S_RD) || (state_q == S_WR);
  assign drp_we_o   = (state_q == S_WR);
  assign drp_addr_o = cur_addr;
  assign drp_di_o   = (rd_q & ~cur_mask) | (cur_val & cur_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    last_rd_addr_q <= '0;
    else if (drp_en_o && !drp_we_o) last_rd_addr_q <= drp_addr_o;
  end

  p_single_en_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drp_en_o |=> !drp_en_o);
  p_rmw_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drp_en_o && drp_we_o) |-> drp_addr_o == last_rd_addr_q);
  p_first_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && !bad_cfg) |=> ##1 (drp_en_o && drp_addr_o == 7'h08));
  p_zero_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && bad_cfg) |=> (error_o && !drp_en_o));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_err_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> ($stable(m_q) && $stable(d_q) && $stable(o_q)));
endmodule

// File: tb/clk_reconf_seq_tb.sv
module clk_reconf_seq_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] mult = '0, dv = '0;
  logic [7:0] odv = '0;
  logic [15:0] tmo = 16'd3;
  logic done, err, en, we, rdy = 1'b0;
  logic [6:0] addr;
  logic [15:0] di, dout = '0;

  always #(PERIOD / 2) clk = ~clk;

  clk_reconf_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mult_i(mult), .div_i(dv),
    .odiv_i(odv), .timeout_i(tmo), .done_o(done), .error_o(err),
    .drp_en_o(en), .drp_we_o(we), .drp_addr_o(addr), .drp_di_o(di),
    .drp_do_i(dout), .drp_rdy_i(rdy)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // register model
  logic [15:0] mem [128];
  logic [6:0]  acc_addr [64];
  logic        acc_we [64];
  int n_acc = 0, lat = 1, cyc = 0, due = 0;
  logic pend = 1'b0, clr = 1'b0, p_we = 1'b0;
  logic [6:0] p_addr = '0;
  logic [15:0] p_di = '0;

  function automatic logic [15:0] init_val(input int a);
    return 16'hc35a ^ 16'(a * 257);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rdy <= 1'b0;
    if (clr) begin
      for (int a = 0; a < 128; a++) mem[a] <= init_val(a);
      n_acc <= 0;
      pend  <= 1'b0;
    end else if (en) begin
      if (n_acc < 64) begin
        acc_addr[n_acc] <= addr;
        acc_we[n_acc]   <= we;
      end
      n_acc <= n_acc + 1;
      if (lat <= 1) begin
        rdy  <= 1'b1;
        dout <= mem[addr];
        if (we) mem[addr] <= di;
      end else begin
        pend <= 1'b1; due <= cyc + lat - 1;
        p_addr <= addr; p_we <= we; p_di <= di;
      end
    end else if (pend && cyc == due) begin
      rdy  <= 1'b1;
      dout <= mem[p_addr];
      if (p_we) mem[p_addr] <= p_di;
      pend <= 1'b0;
    end
  end

  // expected values
  function automatic int s_addr(input int i);
    case (i)
      0: return 'h08; 1: return 'h09; 2: return 'h16; 3: return 'h14; 4: return 'h15;
      5: return 'h18; 6: return 'h19; 7: return 'h1a; 8: return 'h4e; default: return 'h4f;
    endcase
  endfunction

  function automatic int s_mask(input int i);
    case (i)
      0, 3: return 'hefff; 1, 4, 5: return 'h03ff; 2: return 'h3fff;
      6, 7: return 'h7fff; default: return 'h9900;
    endcase
  endfunction

  function automatic int b_filter(input int x);
    case (x) inside
      0: return 'h01001990;  1: return 'h01001190;  2: return 'h01009890;
      3: return 'h01001890;  4: return 'h01008890;  [5:8]: return 'h01009090;
      [9:11]: return 'h01000890; 12: return 'h08009090; [13:22]: return 'h01001090;
      [23:36]: return 'h01008090; [37:46]: return 'h08001090;
      default: return 'h08008090;
    endcase
  endfunction

  localparam int LK_LO [10] = '{6, 6, 8, 11, 14, 17, 19, 22, 25, 28};
  localparam int LK_HI [26] = '{'h384, 'h339, 'h2ee, 'h2bc, 'h28a, 'h271, 'h23f,
    'h226, 'h20d, 'h1f4, 'h1db, 'h1c2, 'h1a9, 'h190, 'h190, 'h177, 'h15e, 'h15e,
    'h145, 'h145, 'h12c, 'h12c, 'h12c, 'h113, 'h113, 'h113};

  function automatic int b_lock(input int x);
    if (x < 10)  return (LK_LO[x] << 24) | (LK_LO[x] << 16) | 'h3e8;
    if (x < 36)  return 'h1f1f0000 | LK_HI[x - 10];
    return 'h1f1f00fa;
  endfunction

  function automatic int s_val(input int i, input int m, input int d, input int o);
    int n, hi, lo, lk, fl;
    n  = (i < 2) ? o : (i == 2) ? d : m;
    hi = n / 2; lo = n - hi;
    lk = b_lock(m - 1); fl = b_filter(m - 1);
    case (i)
      0, 3: return (hi << 6) | lo;                                          // R3
      1, 4: return ((n % 2) << 7) | ((n == 1) << 6);                        // R3
      2:    return ((n % 2) << 13) | ((n == 1) << 12) | (hi << 6) | lo;     // R3
      5:    return lk & 'h3ff;                                              // R4
      6:    return (((lk >> 16) & 'h1f) << 10) | 1;                         // R4
      7:    return (((lk >> 24) & 'h1f) << 10) | 'h3e9;                     // R4
      8:    return (fl >> 16) & 'hffff;                                     // R5
      default: return fl & 'hffff;                                          // R5
    endcase
  endfunction

  task automatic clear_model();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic pulse_start(input int m, input int d, input int o);
    mult = 7'(m); dv = 7'(d); odv = 8'(o);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // waits for done or error; returns 1 on done, 0 on error, -1 on stall
  task automatic wait_end(output int res);
    res = -1;
    for (int k = 0; k < 3000; k++) begin
      if (done) begin res = 1; break; end
      if (err)  begin res = 0; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_regs(input int m, input int d, input int o, input string tag);
    for (int i = 0; i < 10; i++) begin
      int a, exp;
      a   = s_addr(i);
      exp = (init_val(a) & ~s_mask(i) & 'hffff) | (s_val(i, m, d, o) & s_mask(i));
      chk(mem[a] == 16'(exp), tag, mem[a], exp);
    end
  endtask

  task automatic full_run(input int m, input int d, input int o, input int l);
    int res;
    lat = l;
    clear_model();
    pulse_start(m, d, o);
    wait_end(res);
    chk(res == 1, "R9 done", res, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 one-cycle done", done, 0);
    chk(n_acc == 20, "R11 access count", n_acc, 20);
    for (int k = 0; k < 20; k++) begin
      chk(acc_addr[k] == 7'(s_addr(k / 2)), "R1 order", acc_addr[k], s_addr(k / 2));
      chk(acc_we[k] == 1'(k % 2), "R2 read then write", acc_we[k], k % 2);
    end
    check_regs(m, d, o, "R2/R3/R4/R5/R6 merged value");
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int res;
    repeat (3) @(negedge clk);
    chk(done == 0 && err == 0 && en == 0, "R12 reset outputs", {done, err, en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && err == 0 && en == 0, "R12 idle outputs", {done, err, en}, 0);

    // sweep M over both table ends, mixed dividers and latencies
    tmo = 16'd3;
    for (int m = 1; m <= 72; m++)
      full_run(m, ((m * 7) % 80) + 1, ((m * 13) % 128) + 1, (m % 3) + 1);
    full_run(1, 1, 1, 1);       // R3 bypass on every divider
    full_run(64, 80, 128, 2);   // R6 index past the lock table

    // R7 zero settings rejected
    for (int z = 0; z < 3; z++) begin
      clear_model();
      mult = (z == 0) ? 7'd0 : 7'd5;
      dv   = (z == 1) ? 7'd0 : 7'd5;
      odv  = (z == 2) ? 8'd0 : 8'd5;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(err == 1'b1, "R7 error pulse", err, 1);
      @(negedge clk);
      chk(err == 1'b0, "R7 error one cycle", err, 0);
      repeat (20) @(negedge clk);
      chk(n_acc == 0, "R7 no access", n_acc, 0);
    end

    // R8 timeout threshold: latency timeout+1 passes, timeout+2 aborts
    tmo = 16'd3;
    full_run(7, 4, 9, 4);
    lat = 5;
    clear_model();
    pulse_start(7, 4, 9);
    wait_end(res);
    chk(res == 0, "R8 timeout error", res, 0);
    repeat (30) @(negedge clk);
    chk(n_acc == 1, "R8 abort after timeout", n_acc, 1);
    chk(mem[8'h08] == init_val('h08), "R8 register untouched", mem[8'h08], init_val('h08));

    // R10 start ignored while busy
    tmo = 16'd3;
    lat = 2;
    clear_model();
    pulse_start(5, 3, 7);
    repeat (10) @(negedge clk);
    pulse_start(9, 2, 2);
    wait_end(res);
    chk(res == 1, "R10 run completes", res, 1);
    repeat (200) begin
      @(negedge clk);
      if (done) chk(0, "R10 second done", 1, 0);
    end
    chk(n_acc == 20, "R10 access count", n_acc, 20);
    check_regs(5, 3, 7, "R10 first settings kept");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule